// File: doc/BRIEF.md
# Multichannel ADC serial frame controller

This block is the digital side of an eight-input, 12-bit sampling converter that is driven over a four-wire serial port. A host lowers the chip select and supplies 16 serial clocks. In that one frame the block takes in an 8-bit control word on the data input and sends the 16-bit result of the current conversion on the data output. The serial clock also times the conversion. The analog sampling, comparator, capacitor array and reference sit outside the block. A behavioural result source returns the 12-bit code for the channel that the block selects.

All pins are brought into the system clock domain through a synchroniser. Every frame event is decoded from the rising and falling serial clock edges, counted from the start of the frame: sample-hold, control capture, channel and mode update, and automatic sleep and wake. The block drives power-up and power-down strobes, core and reference enables, and a flag that marks a conversion as taken too soon after waking from auto-shutdown.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset the data output is not driven, the core and reference are on, channel 0 is selected, and the invalid flag and all strobes are low.
- R2: A frame is 16 rising SCLK edges with CS low. DIN is taken on the first 8 rising edges, MSB first, as the control word. Bits [5:3] hold the channel, bit 2 is reference-off, and bits [1:0] hold the mode.
- R3: The data output is driven only while CS is low. Each falling SCLK edge launches the next bit of a 16-bit word made of four zeros and then the 12-bit code, MSB first.
- R4: The result code is sampled with a one-cycle hold pulse on the 2nd rising SCLK edge of the frame.
- R5: The channel written in a frame is applied on its 16th rising edge and is used by the following conversion. The selected channel is shown on chan_o.
- R6: The reference-off bit takes effect on the 8th rising edge. A value of 1 turns the reference off.
- R7: Mode 00 keeps the core on. Mode 01 turns core and reference off on the 16th rising edge, and later frames do not wake it. Writing 00 again powers the core up on the 16th rising edge of that frame.
- R8: In modes 10 and 11 the core powers down on the 16th rising edge and powers up on the first falling edge of the next frame. Each transition raises a one-cycle strobe.
- R9: While asleep, mode 11 keeps the reference on and mode 10 turns it off.
- R10: If CS stays low after 16 clocks, the next frame starts at once with no CS edge.
- R11: A CS rise in mid-frame aborts the frame. With fewer than 8 bits received nothing changes. With 8 to 15 bits the reference bit updates but the channel and mode do not.
- R12: In mode 10 the invalid flag is set at the hold edge when fewer than WAKE_CLKS system clocks have passed since the wake edge, and is cleared otherwise. In all other modes it is cleared.
- R13: Control bits 7 and 6 have no effect on the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial and conversion clock, idles high |
| din_i | input | 1 | Serial control data |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for dout_o |
| chan_o | output | 3 | Channel given to the result source |
| code_i | input | 12 | Result code for chan_o |
| hold_o | output | 1 | Sample-hold pulse |
| core_on_o | output | 1 | Converter core powered |
| ref_on_o | output | 1 | Reference powered |
| pwr_up_o | output | 1 | Power-up strobe |
| pwr_dn_o | output | 1 | Power-down strobe |
| conv_bad_o | output | 1 | Last conversion taken before the wake time ran out |

## Verification
A pin change is seen after two synchroniser stages plus one edge register. Registered results therefore follow about three system clocks after the SCLK or CS edge that causes them. The bench holds each SCLK level for eight system clocks or more. It samples the data output just before the rising edge that would sample it, and it reads the levels (enables, channel, flag) one half-period after CS rises. The strobes are counted as they occur, and each one is tagged with the number of edges driven so far, which shows the SCLK edge that produced it.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;
  localparam int unsigned FRAME_LEN = 16;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned CTRL_LEN  = 8;
  localparam int unsigned CODE_W    = 12;
  localparam int unsigned LEAD_LEN  = FRAME_LEN - CODE_W;
  localparam int unsigned CHAN_W    = 3;
  localparam int unsigned HOLD_EDGE = 2;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_SHUTDOWN = 2'b01,
    PM_AUTO_OFF = 2'b10,
    PM_AUTO_STB = 2'b11
  } pm_mode_e;

  // used low bits of the control word; top bits shift out unused
  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              ref_off;
    pm_mode_e          pm;
  } ctrl_t;

  localparam int unsigned USED_LEN = $bits(ctrl_t);
endpackage

// File: rtl/adc_fc_sync.sv
module adc_fc_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_fc_frame.sv
module adc_fc_frame
  import adc_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              launch_o,
  output logic              first_fall_o,
  output logic              hold_o,
  output logic              frame_end_o,
  output logic              ref_off_o,
  output pm_mode_e          pend_mode_o,
  output logic [CHAN_W-1:0] chan_o,
  output pm_mode_e          mode_o
);
  logic             sclk_prev_q;
  logic             rise, fall;
  logic [POS_W-1:0] pos_q;
  logic [USED_LEN-2:0] shift_q;
  ctrl_t            ctrl_q;
  logic [CHAN_W-1:0] chan_q;
  pm_mode_e         mode_q;
  logic             commit;

  assign rise = active_i & sclk_i & ~sclk_prev_q;
  assign fall = active_i & ~sclk_i & sclk_prev_q;

  assign commit      = rise && (pos_q == POS_W'(CTRL_LEN - 1));
  assign frame_end_o = rise && (pos_q == POS_W'(FRAME_LEN - 1));
  assign hold_o      = rise && (pos_q == POS_W'(HOLD_EDGE - 1));
  assign first_fall_o = fall && (pos_q == '0);
  assign launch_o    = fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      pos_q       <= '0;
      shift_q     <= '0;
      ctrl_q      <= '0;
      chan_q      <= '0;
      mode_q      <= PM_NORMAL;
    end else begin
      sclk_prev_q <= sclk_i;
      if (!active_i) begin
        pos_q <= '0;
      end else if (rise) begin
        pos_q <= frame_end_o ? '0 : pos_q + 1'b1;
        if (pos_q < POS_W'(CTRL_LEN - 1))
          shift_q <= {shift_q[USED_LEN-3:0], din_i};
        if (commit)
          ctrl_q <= ctrl_t'({shift_q, din_i});
        if (frame_end_o) begin
          chan_q <= ctrl_q.chan;
          mode_q <= ctrl_q.pm;
        end
      end
    end
  end

  assign pos_o       = pos_q;
  assign ref_off_o   = ctrl_q.ref_off;
  assign pend_mode_o = ctrl_q.pm;
  assign chan_o      = chan_q;
  assign mode_o      = mode_q;

  // R5: selection moves only on the last edge of a whole frame
  assert_chan_pipe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_o |=> $stable(chan_q));
  // R11: control contents change only once 8 bits have arrived
  assert_ctrl_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ctrl_q));
endmodule

// File: rtl/adc_fc_dout.sv
module adc_fc_dout
  import adc_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              launch_i,
  input  logic              hold_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              dout_o,
  output logic              oe_o
);
  logic [CODE_W-1:0]    res_q;
  logic [FRAME_LEN-1:0] word;
  logic                 dout_q, oe_q;

  assign word = {LEAD_LEN'(0), res_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (hold_i) res_q <= code_i;
      if (!active_i) begin
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
      end else begin
        oe_q <= 1'b1;
        if (launch_i) dout_q <= word[POS_W'(FRAME_LEN - 1) - pos_i];
      end
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;

  // R3: leading bits of every frame are zero
  assert_lead_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && pos_i < POS_W'(LEAD_LEN)) |=> !dout_q);
  // R4: sampling happens only inside a driven frame
  assert_hold_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> oe_q);
endmodule

// File: rtl/adc_fc_pwr.sv
module adc_fc_pwr
  import adc_fc_pkg::*;
#(
  parameter int unsigned WAKE_CLKS = 1250
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     first_fall_i,
  input  logic     hold_i,
  input  logic     frame_end_i,
  input  logic     ref_off_i,
  input  pm_mode_e pend_mode_i,
  input  pm_mode_e mode_i,
  output logic     core_on_o,
  output logic     ref_on_o,
  output logic     up_o,
  output logic     dn_o,
  output logic     bad_o
);
  localparam int unsigned WCW = $clog2(WAKE_CLKS + 1);

  logic           awake_q, awake_n;
  logic           up_q, dn_q, bad_q;
  logic [WCW-1:0] wcnt_q;
  logic           auto_mode, wake_evt;

  assign auto_mode = (mode_i == PM_AUTO_OFF) || (mode_i == PM_AUTO_STB);
  assign wake_evt  = first_fall_i && auto_mode && !awake_q;

  always_comb begin
    awake_n = awake_q;
    if (frame_end_i)   awake_n = (pend_mode_i == PM_NORMAL);
    else if (wake_evt) awake_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awake_q <= 1'b1;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      bad_q   <= 1'b0;
      wcnt_q  <= WCW'(WAKE_CLKS);
    end else begin
      awake_q <= awake_n;
      up_q    <= awake_n & ~awake_q;
      dn_q    <= ~awake_n & awake_q;
      if (wake_evt)                        wcnt_q <= '0;
      else if (wcnt_q < WCW'(WAKE_CLKS))   wcnt_q <= wcnt_q + 1'b1;
      if (hold_i)
        bad_q <= (mode_i == PM_AUTO_OFF) && (wcnt_q < WCW'(WAKE_CLKS));
    end
  end

  assign core_on_o = awake_q;
  assign ref_on_o  = !ref_off_i && (awake_q || mode_i == PM_AUTO_STB);
  assign up_o      = up_q;
  assign dn_o      = dn_q;
  assign bad_o     = bad_q;

  // R8: an auto mode is awake by the time it samples
  assert_awake_at_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && auto_mode) |-> awake_q);
  // R7: a power-down always lands in a non-normal mode
  assert_dn_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_q |-> (mode_i != PM_NORMAL));
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_fc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_CLKS   = 1250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [CHAN_W-1:0] chan_o,
  input  logic [CODE_W-1:0] code_i,
  output logic              hold_o,
  output logic              core_on_o,
  output logic              ref_on_o,
  output logic              pwr_up_o,
  output logic              pwr_dn_o,
  output logic              conv_bad_o
);
  logic [2:0]       pins_s;
  logic             active, launch, first_fall, hold, frame_end, ref_off;
  logic [POS_W-1:0] pos;
  pm_mode_e         pend_mode, mode;

  adc_fc_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  assign active = ~pins_s[2];

  adc_fc_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .sclk_i      (pins_s[1]),
    .din_i       (pins_s[0]),
    .pos_o       (pos),
    .launch_o    (launch),
    .first_fall_o(first_fall),
    .hold_o      (hold),
    .frame_end_o (frame_end),
    .ref_off_o   (ref_off),
    .pend_mode_o (pend_mode),
    .chan_o      (chan_o),
    .mode_o      (mode)
  );

  adc_fc_dout u_dout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .launch_i(launch),
    .hold_i  (hold),
    .pos_i   (pos),
    .code_i  (code_i),
    .dout_o  (dout_o),
    .oe_o    (dout_oe_o)
  );

  adc_fc_pwr #(.WAKE_CLKS(WAKE_CLKS)) u_pwr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .first_fall_i(first_fall),
    .hold_i      (hold),
    .frame_end_i (frame_end),
    .ref_off_i   (ref_off),
    .pend_mode_i (pend_mode),
    .mode_i      (mode),
    .core_on_o   (core_on_o),
    .ref_on_o    (ref_on_o),
    .up_o        (pwr_up_o),
    .dn_o        (pwr_dn_o),
    .bad_o       (conv_bad_o)
  );

  assign hold_o = hold;
endmodule

// File: tb/adc_frame_ctrl_tb_top.sv
module adc_frame_ctrl_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs = 1'b1, sclk = 1'b1, din = 1'b0;
  logic dout, oe, hold, core_on, ref_on, up, dn, bad;
  logic [2:0]  chan;
  logic [11:0] code;

  int n_chk = 0, n_err = 0;
  int hp = 8;
  int rise_n = 0, fall_n = 0;
  int hold_cnt = 0, up_cnt = 0, dn_cnt = 0;
  int hold_rise = -1, up_rise = -1, up_fall = -1, dn_rise = -1;

  always #2 clk_i = ~clk_i;

  function automatic logic [11:0] model_code(input logic [2:0] ch);
    return 12'((int'(ch) * 499 + 165) % 4096);
  endfunction

  assign code = model_code(chan);

  adc_frame_ctrl #(.SYNC_STAGES(2), .WAKE_CLKS(40)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(oe), .chan_o(chan), .code_i(code), .hold_o(hold),
    .core_on_o(core_on), .ref_on_o(ref_on), .pwr_up_o(up), .pwr_dn_o(dn),
    .conv_bad_o(bad)
  );

  always @(posedge clk_i) begin
    if (hold) begin hold_cnt <= hold_cnt + 1; hold_rise <= rise_n; end
    if (up)   begin up_cnt <= up_cnt + 1; up_rise <= rise_n; up_fall <= fall_n; end
    if (dn)   begin dn_cnt <= dn_cnt + 1; dn_rise <= rise_n; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input logic [7:0] w, input int nrise, input bit keep_low,
                      output logic [15:0] rx);
    rx = '0;
    if (cs) begin cs = 1'b0; wait_clk(hp); end
    rise_n = 0; fall_n = 0;
    for (int i = 0; i < nrise; i++) begin
      sclk = 1'b0; din = (i < 8) ? w[7-i] : 1'b0; fall_n = i + 1;
      wait_clk(hp);
      rx[15-i] = dout;
      sclk = 1'b1; rise_n = i + 1;
      wait_clk(hp);
    end
    if (!keep_low) begin cs = 1'b1; wait_clk(hp); end
  endtask

  // {control word, channel whose code the frame returns}
  localparam logic [10:0] VECS [6] = '{
    {8'h28, 3'd0}, {8'h10, 3'd5}, {8'h38, 3'd2},
    {8'h00, 3'd7}, {8'h18, 3'd0}, {8'hB0, 3'd3}
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    int c0;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 oe", oe, 0);
    chk("R1 core", core_on, 1);
    chk("R1 ref", ref_on, 1);
    chk("R1 chan", chan, 0);
    chk("R1 bad", bad, 0);
    chk("R1 strobes", {hold, up, dn}, 0);

    // R2 R3 R5 R13: table of frames in normal mode
    for (int v = 0; v < 6; v++) begin
      xfer(VECS[v][10:3], 16, 1'b0, rx);
      chk("R3 word", rx, {4'b0, model_code(VECS[v][2:0])});
      chk("R5 R2 chan", chan, VECS[v][8:6]);
      chk("R3 oe off", oe, 0);
      if (v == 0) chk("R4 hold edge", hold_rise, 2);
    end
    chk("R13 ignored bits chan", chan, 6);
    chk("R4 hold count", hold_cnt, 6);
    chk("R7 normal core", core_on, 1);

    // R10 continuous frames
    xfer(8'h08, 16, 1'b1, rx);
    chk("R10 first", rx, {4'b0, model_code(3'd6)});
    xfer(8'h20, 16, 1'b0, rx);
    chk("R10 second", rx, {4'b0, model_code(3'd1)});
    chk("R10 chan", chan, 4);

    // R6 reference bit
    xfer(8'h04, 16, 1'b0, rx);
    chk("R6 ref off", ref_on, 0);
    chk("R6 word", rx, {4'b0, model_code(3'd4)});

    // R11 aborts
    xfer(8'h38, 5, 1'b0, rx);
    chk("R11 short ref", ref_on, 0);
    chk("R11 short chan", chan, 0);
    xfer(8'h38, 10, 1'b0, rx);
    chk("R11 long ref", ref_on, 1);
    chk("R11 long chan", chan, 0);
    xfer(8'h00, 16, 1'b0, rx);
    chk("R11 next code", rx, {4'b0, model_code(3'd0)});

    // R7 full shutdown
    c0 = dn_cnt;
    xfer(8'h01, 16, 1'b0, rx);
    chk("R7 core off", core_on, 0);
    chk("R7 ref off", ref_on, 0);
    chk("R7 dn count", dn_cnt, c0 + 1);
    chk("R7 dn edge", dn_rise, 16);
    c0 = up_cnt;
    xfer(8'h01, 16, 1'b0, rx);
    chk("R7 stays off", core_on, 0);
    chk("R7 no wake", up_cnt, c0);
    xfer(8'h00, 16, 1'b0, rx);
    chk("R7 wake core", core_on, 1);
    chk("R7 wake edge", up_rise, 16);
    chk("R7 ref back", ref_on, 1);

    // R8 R9 R12 auto-shutdown
    xfer(8'h02, 16, 1'b0, rx);
    chk("R8 sleep", core_on, 0);
    chk("R8 dn edge", dn_rise, 16);
    chk("R9 ref off asleep", ref_on, 0);
    c0 = up_cnt;
    xfer(8'h02, 16, 1'b0, rx);
    chk("R8 up count", up_cnt, c0 + 1);
    chk("R8 up edge", {up_fall[7:0], up_rise[7:0]}, {8'd1, 8'd0});
    chk("R8 code", rx, {4'b0, model_code(3'd0)});
    chk("R12 fast wake", bad, 1);
    chk("R8 resleep", core_on, 0);
    hp = 16;
    xfer(8'h02, 16, 1'b0, rx);
    chk("R12 slow wake", bad, 0);
    hp = 8;
    xfer(8'h02, 16, 1'b0, rx);
    chk("R12 fast again", bad, 1);

    // R9 R12 auto-standby
    xfer(8'h03, 16, 1'b0, rx);
    chk("R9 standby core", core_on, 0);
    chk("R9 standby ref", ref_on, 1);
    xfer(8'h03, 16, 1'b0, rx);
    chk("R12 standby flag", bad, 0);
    chk("R8 standby code", rx, {4'b0, model_code(3'd0)});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule